// File: doc/BRIEF.md
# Move-Slot Transport Network

This block is the data transport fabric of a processor that has only one kind of instruction: a move. Each long instruction word holds one move slot per transport bus. Each slot carries a valid bit, a source code and a destination code. The block decodes every slot directly from these fields. It drives the slot's bus from the chosen source: a register-file read port, a function-unit result, or the immediate field that all slots share. It then raises the write enable of the chosen destination: a function-unit operand port, a function-unit trigger port, or a register-file write port. Writing a trigger port is what starts a computation, so the block contains no opcode logic.

Function-unit results can be selected as a source in the same cycle they are presented. A result can therefore go straight into another unit's operand or trigger port without passing through the register file. Each destination socket registers its enable and data. A destination sees a move one clock edge after the instruction word is presented.

Two valid slots in one word may name the same destination. In that case the lowest-numbered bus wins and a conflict flag is raised. A global lock input stops every destination write.

Top module: `tta_move_net`

## Requirements
- R1: Source codes 0 to 3 put register-file read port `src` (`rf_rdata[src*16 +: 16]`) on the slot's bus.
- R2: Source codes 8 to 11 put function-unit result `src-8` on the bus in the same cycle, with no register in that path (software bypass).
- R3: Source code 31 puts the shared 16-bit `imm` field on the bus.
- R4: Destination codes 0 to 3 select operand port n, codes 8 to 11 select trigger port n-8, and codes 16 to 19 select register-file write port n-16. The selected enable is high for exactly the one clock edge after the word, with the bus data. A data output keeps its last written value while its enable is low.
- R5: A slot with `slot_valid` low causes no write on any destination.
- R6: The three buses carry independent moves in the same word. Bus b uses bits `[b*5 +: 5]` of `slot_src` and `slot_dst`.
- R7: If two or more valid slots name the same defined destination, `conflict` is high one edge later and the lowest-numbered of those buses supplies the data.
- R8: While `glock` is high, no write enable rises and the data outputs hold. The conflict flag is still evaluated.
- R9: Undefined source codes put zero on the bus. Undefined destination codes write nothing and never count toward a conflict.
- R10: After reset, all write enables and `conflict` are low and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glock | input | 1 | Global lock; blocks all destination writes |
| slot_valid | input | 3 | Valid bit of each move slot |
| slot_src | input | 15 | Source code of each slot, 5 bits per bus |
| slot_dst | input | 15 | Destination code of each slot, 5 bits per bus |
| imm | input | 16 | Shared immediate field |
| rf_rdata | input | 64 | Register-file read port data, 16 bits per port |
| fu_result | input | 64 | Function-unit result data, 16 bits per unit |
| opnd_we | output | 4 | Operand port write enables |
| opnd_data | output | 64 | Operand port data |
| trig_we | output | 4 | Trigger port write enables |
| trig_data | output | 64 | Trigger port data |
| rf_we | output | 4 | Register-file write enables |
| rf_wdata | output | 64 | Register-file write data |
| conflict | output | 1 | Destination collision seen in the previous word |

## Verification
The assertions check, on every cycle, these timing rules:
- the lock blocks all writes;
- an enable follows a decoded hit and nothing else;
- a word with no valid slot produces no write;
- the conflict flag follows a real destination overlap.

The bench's reference model is needed for the rest. It checks the source-to-bus mapping for each code range, and the same-cycle result bypass. It checks that the lowest bus wins a collision, that data holds under lock, and that undefined codes are handled as stated. These are compared through directed scenarios and a long randomized run.

// File: rtl/tta_pkg.sv
package tta_pkg;
  localparam int SRC_RF_BASE   = 0;
  localparam int SRC_FU_BASE   = 8;
  localparam int SRC_IMM_CODE  = 31;
  localparam int DST_OPND_BASE = 0;
  localparam int DST_TRIG_BASE = 8;
  localparam int DST_RF_BASE   = 16;

  typedef enum logic [1:0] {
    DK_OPND = 2'd0,
    DK_TRIG = 2'd1,
    DK_RFWR = 2'd2
  } dst_kind_e;
endpackage

// File: rtl/tta_src_mux.sv
module tta_src_mux #(
  parameter int DW     = 16,
  parameter int SW     = 5,
  parameter int NUM_RD = 4,
  parameter int NUM_FU = 4
) (
  input  logic [SW-1:0]        src,
  input  logic [DW-1:0]        imm,
  input  logic [NUM_RD*DW-1:0] rf_rdata,
  input  logic [NUM_FU*DW-1:0] fu_result,
  output logic [DW-1:0]        bus_data
);
  import tta_pkg::*;

  always_comb begin
    bus_data = '0;
    for (int i = 0; i < NUM_RD; i++) begin
      if (int'(src) == SRC_RF_BASE + i) bus_data = rf_rdata[i*DW +: DW];
    end
    for (int i = 0; i < NUM_FU; i++) begin
      if (int'(src) == SRC_FU_BASE + i) bus_data = fu_result[i*DW +: DW];
    end
    if (int'(src) == SRC_IMM_CODE) bus_data = imm;
  end
endmodule

// File: rtl/tta_dst_decode.sv
module tta_dst_decode #(
  parameter int SW      = 5,
  parameter int NUM_FU  = 4,
  parameter int NUM_WR  = 4,
  parameter int NUM_DST = 2*NUM_FU + NUM_WR
) (
  input  logic               valid,
  input  logic [SW-1:0]      dst,
  output logic [NUM_DST-1:0] hit
);
  import tta_pkg::*;

  always_comb begin
    hit = '0;
    if (valid) begin
      for (int i = 0; i < NUM_FU; i++) begin
        if (int'(dst) == DST_OPND_BASE + i) hit[i] = 1'b1;
        if (int'(dst) == DST_TRIG_BASE + i) hit[NUM_FU + i] = 1'b1;
      end
      for (int i = 0; i < NUM_WR; i++) begin
        if (int'(dst) == DST_RF_BASE + i) hit[2*NUM_FU + i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tta_dst_port.sv
module tta_dst_port #(
  parameter int NUM_BUS = 3,
  parameter int DW      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  glock,
  input  logic [NUM_BUS-1:0]    hit,
  input  logic [NUM_BUS*DW-1:0] bus_data,
  output logic                  we,
  output logic [DW-1:0]         data,
  output logic                  clash
);
  logic          found;
  logic [DW-1:0] sel_data;
  logic          we_d, we_q;
  logic [DW-1:0] data_d, data_q;

  always_comb begin
    found    = 1'b0;
    sel_data = '0;
    for (int b = 0; b < NUM_BUS; b++) begin
      if (hit[b] && !found) begin
        found    = 1'b1;
        sel_data = bus_data[b*DW +: DW];
      end
    end
    clash  = ($countones(hit) > 1);
    we_d   = found & ~glock;
    data_d = we_d ? sel_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      data_q <= '0;
    end else begin
      we_q   <= we_d;
      data_q <= data_d;
    end
  end

  assign we   = we_q;
  assign data = data_q;

  AST_LOCK_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    glock |=> !we); // R8
  AST_HIT_GIVES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit && !glock) |=> we); // R4
  AST_NO_HIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit) |=> !we); // R5
endmodule

// File: rtl/tta_move_net.sv
module tta_move_net #(
  parameter int NUM_BUS = 3,
  parameter int DW      = 16,
  parameter int SW      = 5,
  parameter int NUM_RD  = 4,
  parameter int NUM_WR  = 4,
  parameter int NUM_FU  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  glock,
  input  logic [NUM_BUS-1:0]    slot_valid,
  input  logic [NUM_BUS*SW-1:0] slot_src,
  input  logic [NUM_BUS*SW-1:0] slot_dst,
  input  logic [DW-1:0]         imm,
  input  logic [NUM_RD*DW-1:0]  rf_rdata,
  input  logic [NUM_FU*DW-1:0]  fu_result,
  output logic [NUM_FU-1:0]     opnd_we,
  output logic [NUM_FU*DW-1:0]  opnd_data,
  output logic [NUM_FU-1:0]     trig_we,
  output logic [NUM_FU*DW-1:0]  trig_data,
  output logic [NUM_WR-1:0]     rf_we,
  output logic [NUM_WR*DW-1:0]  rf_wdata,
  output logic                  conflict
);
  localparam int NUM_DST = 2*NUM_FU + NUM_WR;

  logic [NUM_BUS*DW-1:0]         bus_data;
  logic [NUM_BUS-1:0][NUM_DST-1:0] bus_hit;
  logic [NUM_DST-1:0][NUM_BUS-1:0] dst_hit;
  logic [NUM_DST-1:0]            dst_we;
  logic [NUM_DST*DW-1:0]         dst_data;
  logic [NUM_DST-1:0]            dst_clash;
  logic                          conflict_d, conflict_q;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    tta_src_mux #(.DW(DW), .SW(SW), .NUM_RD(NUM_RD), .NUM_FU(NUM_FU)) u_src (
      .src       (slot_src[b*SW +: SW]),
      .imm       (imm),
      .rf_rdata  (rf_rdata),
      .fu_result (fu_result),
      .bus_data  (bus_data[b*DW +: DW])
    );
    tta_dst_decode #(.SW(SW), .NUM_FU(NUM_FU), .NUM_WR(NUM_WR), .NUM_DST(NUM_DST)) u_dec (
      .valid (slot_valid[b]),
      .dst   (slot_dst[b*SW +: SW]),
      .hit   (bus_hit[b])
    );
  end

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_tr
      assign dst_hit[d][b] = bus_hit[b][d];
    end
    tta_dst_port #(.NUM_BUS(NUM_BUS), .DW(DW)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .glock    (glock),
      .hit      (dst_hit[d]),
      .bus_data (bus_data),
      .we       (dst_we[d]),
      .data     (dst_data[d*DW +: DW]),
      .clash    (dst_clash[d])
    );
  end

  assign opnd_we   = dst_we[NUM_FU-1:0];
  assign trig_we   = dst_we[2*NUM_FU-1:NUM_FU];
  assign rf_we     = dst_we[NUM_DST-1:2*NUM_FU];
  assign opnd_data = dst_data[NUM_FU*DW-1:0];
  assign trig_data = dst_data[2*NUM_FU*DW-1:NUM_FU*DW];
  assign rf_wdata  = dst_data[NUM_DST*DW-1:2*NUM_FU*DW];

  always_comb conflict_d = |dst_clash;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conflict_q <= 1'b0;
    else        conflict_q <= conflict_d;
  end

  assign conflict = conflict_q;

  // Pairwise overlap of decoded hits, used only by the checks below
  logic pair_overlap;
  always_comb begin
    pair_overlap = 1'b0;
    for (int i = 0; i < NUM_BUS; i++)
      for (int j = i + 1; j < NUM_BUS; j++)
        if (|(bus_hit[i] & bus_hit[j])) pair_overlap = 1'b1;
  end

  AST_OVERLAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    pair_overlap |=> conflict); // R7
  AST_NO_FALSE_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_overlap |=> !conflict); // R9
  AST_IDLE_WORD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(|slot_valid) |=> !(|dst_we)); // R5
endmodule

// File: tb/tb_tta_move_net.sv
module tb_tta_move_net;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3, DW = 16, NF = 4, NR = 4, ND = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glock = 1'b0;
  logic [NB-1:0] slot_valid = '0;
  logic [NB*5-1:0] slot_src = '0, slot_dst = '0;
  logic [DW-1:0] imm = '0;
  logic [NR*DW-1:0] rf_rdata = '0;
  logic [NF*DW-1:0] fu_result = '0;
  logic [NF-1:0] opnd_we, trig_we;
  logic [NR-1:0] rf_we;
  logic [NF*DW-1:0] opnd_data, trig_data;
  logic [NR*DW-1:0] rf_wdata;
  logic conflict;

  int errors = 0, checks = 0, cycles = 0;
  bit exp_we[ND];
  logic [DW-1:0] exp_data[ND];
  bit exp_conf;

  always #(CLK_PERIOD/2) clk = ~clk;

  tta_move_net dut (.*);

  function automatic logic [DW-1:0] src_val(int s);
    if (s >= 0 && s < 4) return rf_rdata[s*DW +: DW];
    if (s >= 8 && s < 12) return fu_result[(s-8)*DW +: DW];
    if (s == 31) return imm;
    return '0;
  endfunction

  function automatic int dst_idx(int d);
    if (d >= 0 && d < 4) return d;
    if (d >= 8 && d < 12) return 4 + d - 8;
    if (d >= 16 && d < 20) return 8 + d - 16;
    return -1;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(string tag);
    logic [ND-1:0] aw, ew;
    logic [ND*DW-1:0] ad, ed;
    aw = {rf_we, trig_we, opnd_we};
    ad = {rf_wdata, trig_data, opnd_data};
    for (int i = 0; i < ND; i++) begin
      ew[i] = exp_we[i];
      ed[i*DW +: DW] = exp_data[i];
    end
    checks++;
    if (aw !== ew || ad !== ed || conflict !== exp_conf) begin
      errors++;
      $display("FAIL %s: we=%h data=%h conf=%b expected we=%h data=%h conf=%b",
               tag, aw, ad, conflict, ew, ed, exp_conf);
    end
  endtask

  // Apply the present inputs through one edge in the model and the DUT, then compare
  task automatic step(string tag);
    int cnt[ND];
    bit cf = 0;
    for (int i = 0; i < ND; i++) cnt[i] = 0;
    for (int i = 0; i < ND; i++) exp_we[i] = 0;
    for (int b = 0; b < NB; b++) begin
      int di;
      if (!slot_valid[b]) continue;
      di = dst_idx(int'(slot_dst[b*5 +: 5]));
      if (di < 0) continue;
      cnt[di]++;
      if (cnt[di] > 1) cf = 1;
      if (cnt[di] == 1 && !glock) begin
        exp_we[di] = 1;
        exp_data[di] = src_val(int'(slot_src[b*5 +: 5]));
      end
    end
    exp_conf = cf;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic slot(int b, bit v, int s, int d);
    slot_valid[b] = v;
    slot_src[b*5 +: 5] = 5'(s);
    slot_dst[b*5 +: 5] = 5'(d);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    for (int i = 0; i < ND; i++) begin exp_we[i] = 0; exp_data[i] = '0; end
    exp_conf = 0;
    for (int i = 0; i < NR; i++) rf_rdata[i*DW +: DW] = 16'h1100 + 16'(i);
    for (int i = 0; i < NF; i++) fu_result[i*DW +: DW] = 16'hA0A0 + 16'(i*16);
    imm = 16'h5A3C;
    repeat (3) @(negedge clk);
    check("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release");

    slot(0, 1, 2, 16); slot(1, 0, 0, 0); slot(2, 0, 0, 0);
    step("R1 rf read to rf write");
    slot(0, 0, 0, 0); slot(1, 1, 9, 8);
    step("R2 bypass fu1 to trig0");
    fu_result[3*DW +: DW] = 16'hBEEF;
    slot(0, 1, 1, 2); slot(1, 1, 11, 9); slot(2, 1, 31, 19);
    step("R6 three parallel moves");
    slot(0, 0, 0, 0); slot(1, 0, 0, 0); slot(2, 1, 31, 0);
    step("R3 immediate to opnd0");
    slot(2, 0, 0, 0);
    step("R4 enable drops, data holds");
    slot(0, 0, 3, 1); slot(1, 0, 8, 10); slot(2, 0, 31, 18);
    step("R5 invalid slots");
    slot(0, 1, 0, 1); slot(1, 1, 31, 3); slot(2, 1, 9, 1);
    step("R7 bus0 and bus2 collide");
    slot(0, 1, 3, 17); slot(1, 1, 31, 17); slot(2, 1, 10, 17);
    step("R7 three-way collision");
    glock = 1'b1; imm = 16'h7777;
    slot(0, 1, 31, 0); slot(1, 1, 8, 11); slot(2, 1, 2, 16);
    step("R8 lock blocks writes");
    slot(2, 1, 1, 0);
    step("R8 lock still flags conflict");
    glock = 1'b0;
    slot(0, 1, 20, 17); slot(1, 1, 31, 30); slot(2, 1, 31, 30);
    step("R9 undefined codes");
    slot(0, 1, 31, 5); slot(1, 1, 2, 5); slot(2, 0, 0, 0);
    step("R9 undefined dst no conflict");

    for (int n = 0; n < 400; n++) begin
      glock = ($urandom_range(0, 7) == 0);
      imm = 16'($urandom);
      for (int i = 0; i < NF; i++) fu_result[i*DW +: DW] = 16'($urandom);
      for (int i = 0; i < NR; i++) rf_rdata[i*DW +: DW] = 16'($urandom);
      for (int b = 0; b < NB; b++)
        slot(b, bit'($urandom_range(0, 1)), $urandom_range(0, 31), $urandom_range(0, 23));
      step("R4 random word");
    end

    rst_n = 1'b0;
    for (int i = 0; i < ND; i++) begin exp_we[i] = 0; exp_data[i] = '0; end
    exp_conf = 0;
    #1;
    check("R10 async reset mid-run");
    summary();
  end
endmodule